// File: doc/BRIEF.md
# Multi-Mode Local Interrupt Timer

This block is a per-core programmable timer. It runs in one of three modes. In one-shot mode it counts down once and then stops. In periodic mode it counts down and reloads itself over and over. In deadline mode it compares a stored 64-bit target against a free-running timestamp counter that is kept inside the block. Software programs the timer through a small register write/read port and through a separate write port for the 64-bit deadline value.

When the timer expires it raises a one-cycle interrupt request that carries the programmed vector, unless the mask bit is set. The `timer_armed` output tells power-management logic whether the timer can still fire. `lowpower_ok` is asserted only while the timer is fully disarmed.

In deadline mode the rule for disarming is different. Writes to the count register do nothing in that mode. The only way to release the timer is to write zero to the deadline register. Passing the deadline is not enough.

Top module: `local_timer`

## Requirements
- R1: In one-shot mode, a nonzero write of N to the start-count register (offset 0x380) loads the remaining count with N on the write edge. The count then drops by one per cycle. The interrupt request is high in the cycle that follows the Nth edge after the write, and on that same edge `timer_armed` falls.
- R2: In periodic mode the request fires every N cycles. On each expiry the remaining count reloads from the start count, and `timer_armed` stays high.
- R3: In one-shot or periodic mode, a write of zero to the start-count register stops the timer on the write edge. `timer_armed` drops, and no later request appears.
- R4: In deadline mode, writes to the start-count register are ignored. The stored start count, `timer_armed` and the output requests are all left unchanged. The remaining-count register (offset 0x390) reads as zero in this mode.
- R5: In deadline mode, with a nonzero deadline D, the request fires once, in the cycle after the first cycle in which the timestamp is greater than or equal to D. At that point `ts_value` reads D+1, or more if D was already in the past. It fires exactly once for each deadline write.
- R6: In deadline mode, the timer stays armed after it fires. Only a write of zero to the deadline port, or a mode change, disarms it.
- R7: The mask bit (bit 16 of the entry register) suppresses every request. It does not change `timer_armed`.
- R8: A write to the entry register (offset 0x3A0) whose mode field differs from the current mode disarms the timer and clears the remaining count.
- R9: `lowpower_ok` is high exactly when `timer_armed` is low. After reset the timer is disarmed.
- R10: Each request is one cycle wide, except for back-to-back periodic expiries. `irq_vector` carries the vector field (bits 7:0 of the entry register) that was in force when the timer expired.
- R11: The entry register holds the mode in bits 18:17, encoded as 0 = one-shot, 1 = periodic, 2 = deadline, 3 = treated as one-shot. Registers reset to zero. Reads of unmapped offsets return zero.
- R12: A deadline write made while the timer is not in deadline mode is stored, but it neither arms the timer nor causes a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register write offset |
| reg_wdata | input | CNT_W | Register write data |
| rd_addr | input | ADDR_W | Register read offset |
| rd_data | output | CNT_W | Combinational read data |
| dl_wr_en | input | 1 | Deadline write strobe |
| dl_wdata | input | TS_W | Deadline write data |
| ts_value | output | TS_W | Free-running timestamp |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | VEC_W | Vector carried with the request |
| timer_armed | output | 1 | Timer can still fire |
| lowpower_ok | output | 1 | Timer fully disarmed |

## Verification
The following properties are checked on every cycle:
- a one-shot expiry disarms the timer;
- a periodic expiry reloads the count;
- a zero start-count write stops counting;
- start-count writes in deadline mode leave the stored count unchanged;
- a deadline-mode timer holds its armed state without a deadline write;
- a masked timer never raises a request;
- a request carries the vector that was in force before it.

Some behaviours can only be shown by the bench scenarios. These are the exact expiry cycle against the timestamp, the request count over a window for each period, the fact that a deadline fires once only, and the effect of a mode change on the read-back count.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;

    typedef enum logic [1:0] {
        MODE_ONESHOT  = 2'b00,
        MODE_PERIODIC = 2'b01,
        MODE_DEADLINE = 2'b10,
        MODE_RSVD     = 2'b11
    } tmode_e;

    // Entry register field positions
    localparam int unsigned VEC_LSB  = 0;
    localparam int unsigned MASK_BIT = 16;
    localparam int unsigned MODE_LSB = 17;
    localparam int unsigned MODE_W   = 2;

endpackage

// File: rtl/ltmr_tsc.sv
module ltmr_tsc #(
    parameter int unsigned TS_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] ts
);
    logic [TS_W-1:0] ts_d, ts_q;

    always_comb begin
        ts_d = ts_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_d;
    end

    assign ts = ts_q;
endmodule

// File: rtl/ltmr_decode.sv
module ltmr_decode #(
    parameter int unsigned ADDR_W = 12,
    parameter logic [ADDR_W-1:0] OFF_INIT  = 'h380,
    parameter logic [ADDR_W-1:0] OFF_ENTRY = 'h3A0
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_init,
    output logic              wr_entry
);
    always_comb begin
        wr_init  = wr_en && (addr == OFF_INIT);
        wr_entry = wr_en && (addr == OFF_ENTRY);
    end
endmodule

// File: rtl/ltmr_cmp.sv
module ltmr_cmp #(
    parameter int unsigned TS_W = 64
) (
    input  logic [TS_W-1:0] ts,
    input  logic [TS_W-1:0] target,
    output logic            reached,
    output logic            target_nz
);
    always_comb begin
        reached   = (ts >= target);
        target_nz = (target != '0);
    end
endmodule

// File: rtl/local_timer.sv
module local_timer
    import ltmr_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned TS_W   = 64,
    parameter int unsigned VEC_W  = 8,
    parameter int unsigned ADDR_W = 12,
    parameter logic [ADDR_W-1:0] OFF_INIT  = 'h380,
    parameter logic [ADDR_W-1:0] OFF_CUR   = 'h390,
    parameter logic [ADDR_W-1:0] OFF_ENTRY = 'h3A0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    input  logic              dl_wr_en,
    input  logic [TS_W-1:0]   dl_wdata,
    output logic [TS_W-1:0]   ts_value,
    output logic              irq_valid,
    output logic [VEC_W-1:0]  irq_vector,
    output logic              timer_armed,
    output logic              lowpower_ok
);
    localparam int unsigned ENTRY_TOP = MODE_LSB + MODE_W;

    typedef struct packed {
        logic [CNT_W-1:0] init;
        logic [CNT_W-1:0] cur;
        logic [TS_W-1:0]  dl;
        tmode_e           mode;
        logic             mask;
        logic [VEC_W-1:0] vector;
        logic             armed;
        logic             fired;
        logic             irq;
        logic [VEC_W-1:0] irq_vec;
    } tstate_t;

    tstate_t s_d, s_q;

    logic wr_init, wr_entry;
    logic dl_reached, dl_nz;
    logic [TS_W-1:0] ts;
    tmode_e new_mode;
    logic   fire;

    ltmr_tsc #(.TS_W(TS_W)) u_tsc (
        .clk  (clk),
        .rst_n(rst_n),
        .ts   (ts)
    );

    ltmr_decode #(
        .ADDR_W   (ADDR_W),
        .OFF_INIT (OFF_INIT),
        .OFF_ENTRY(OFF_ENTRY)
    ) u_dec (
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .wr_init (wr_init),
        .wr_entry(wr_entry)
    );

    ltmr_cmp #(.TS_W(TS_W)) u_cmp (
        .ts       (ts),
        .target   (s_q.dl),
        .reached  (dl_reached),
        .target_nz(dl_nz)
    );

    always_comb begin
        s_d      = s_q;
        fire     = 1'b0;
        new_mode = tmode_e'(reg_wdata[MODE_LSB +: MODE_W]);

        // Expiry detection
        if (s_q.armed) begin
            if (s_q.mode == MODE_DEADLINE) begin
                if (!s_q.fired && dl_nz && dl_reached) begin
                    fire      = 1'b1;
                    s_d.fired = 1'b1;
                end
            end else if (s_q.cur <= {{(CNT_W-1){1'b0}}, 1'b1}) begin
                fire = 1'b1;
                if (s_q.mode == MODE_PERIODIC) begin
                    s_d.cur = s_q.init;
                end else begin
                    s_d.cur   = '0;
                    s_d.armed = 1'b0;
                end
            end else begin
                s_d.cur = s_q.cur - 1'b1;
            end
        end

        // Entry register write
        if (wr_entry) begin
            s_d.vector = reg_wdata[VEC_LSB +: VEC_W];
            s_d.mask   = reg_wdata[MASK_BIT];
            s_d.mode   = new_mode;
            if (new_mode != s_q.mode) begin
                s_d.armed = 1'b0;
                s_d.cur   = '0;
                s_d.fired = 1'b0;
                fire      = 1'b0;
            end
        end

        // Start-count write: ignored in deadline mode
        if (wr_init && (s_q.mode != MODE_DEADLINE)) begin
            s_d.init  = reg_wdata;
            s_d.cur   = reg_wdata;
            s_d.armed = (reg_wdata != '0);
            fire      = 1'b0;
        end

        // Deadline write: arms only in deadline mode
        if (dl_wr_en) begin
            s_d.dl = dl_wdata;
            if (s_q.mode == MODE_DEADLINE && !(wr_entry && new_mode != s_q.mode)) begin
                s_d.armed = (dl_wdata != '0);
                s_d.fired = 1'b0;
                fire      = 1'b0;
            end
        end

        s_d.irq     = fire && !s_q.mask;
        s_d.irq_vec = s_q.vector;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Read mux
    always_comb begin
        rd_data = '0;
        if (rd_addr == OFF_INIT) begin
            rd_data = s_q.init;
        end else if (rd_addr == OFF_CUR) begin
            rd_data = (s_q.mode == MODE_DEADLINE) ? '0 : s_q.cur;
        end else if (rd_addr == OFF_ENTRY) begin
            rd_data[VEC_LSB +: VEC_W]  = s_q.vector;
            rd_data[MASK_BIT]          = s_q.mask;
            rd_data[MODE_LSB +: MODE_W] = s_q.mode;
            rd_data[ENTRY_TOP-1]       = s_q.mode[MODE_W-1];
        end
    end

    assign ts_value    = ts;
    assign irq_valid   = s_q.irq;
    assign irq_vector  = s_q.irq_vec;
    assign timer_armed = s_q.armed;
    assign lowpower_ok = !s_q.armed;

endmodule

// File: rtl/ltmr_chk.sv
module ltmr_chk #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_valid,
    input logic [VEC_W-1:0] irq_vector,
    input logic             armed,
    input logic [1:0]       mode,
    input logic             mask,
    input logic [VEC_W-1:0] vector,
    input logic [CNT_W-1:0] init,
    input logic [CNT_W-1:0] cur,
    input logic             wr_init,
    input logic             wr_entry,
    input logic             wr_dl,
    input logic             wdata_zero
);
    localparam logic [1:0] M_ONE = 2'b00;
    localparam logic [1:0] M_PER = 2'b01;
    localparam logic [1:0] M_DL  = 2'b10;

    // R1
    oneshot_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && mode == M_ONE && cur == 1 && !wr_init && !wr_entry) |=> !armed);

    // R2
    periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && mode == M_PER && cur == 1 && !wr_init && !wr_entry)
        |=> (armed && cur == $past(init)));

    // R3
    zero_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_init && wdata_zero && mode != M_DL) |=> !armed);

    // R4
    dl_init_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_init && mode == M_DL) |=> $stable(init));

    // R6
    dl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && mode == M_DL && !wr_dl && !wr_entry) |=> armed);

    // R7
    mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !$past(mask));

    // R10
    vector_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_vector == $past(vector)));

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && mode != M_PER) |=> !irq_valid);
endmodule

bind local_timer ltmr_chk #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_valid (irq_valid),
    .irq_vector(irq_vector),
    .armed     (timer_armed),
    .mode      (s_q.mode),
    .mask      (s_q.mask),
    .vector    (s_q.vector),
    .init      (s_q.init),
    .cur       (s_q.cur),
    .wr_init   (wr_init),
    .wr_entry  (wr_entry),
    .wr_dl     (dl_wr_en),
    .wdata_zero(reg_wdata == '0)
);

// File: tb/local_timer_test.sv
module local_timer_test;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [11:0] A_INIT  = 12'h380;
    localparam logic [11:0] A_CUR   = 12'h390;
    localparam logic [11:0] A_ENTRY = 12'h3A0;

    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] cnt;
        logic [7:0]  win;
        logic [7:0]  irqs;
        logic        armed;
    } vec_t;

    localparam int NVEC = 4;
    localparam vec_t TBL [NVEC] = '{
        '{mode: 2'd0, cnt: 16'd5, win: 8'd20, irqs: 8'd1, armed: 1'b0},
        '{mode: 2'd1, cnt: 16'd4, win: 8'd18, irqs: 8'd4, armed: 1'b1},
        '{mode: 2'd1, cnt: 16'd7, win: 8'd22, irqs: 8'd3, armed: 1'b1},
        '{mode: 2'd0, cnt: 16'd1, win: 8'd5,  irqs: 8'd1, armed: 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        dl_wr_en = 1'b0;
    logic [63:0] dl_wdata = '0;
    logic [63:0] ts_value;
    logic        irq_valid;
    logic [7:0]  irq_vector;
    logic        timer_armed;
    logic        lowpower_ok;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    local_timer uut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .dl_wr_en(dl_wr_en), .dl_wdata(dl_wdata),
        .ts_value(ts_value), .irq_valid(irq_valid), .irq_vector(irq_vector),
        .timer_armed(timer_armed), .lowpower_ok(lowpower_ok)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic wr_dl(input logic [63:0] d);
        dl_wr_en = 1'b1; dl_wdata = d;
        @(negedge clk);
        dl_wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] entry(input logic [1:0] m, input logic msk, input logic [7:0] v);
        return {13'd0, m, msk, 8'd0, v};
    endfunction

    // Counts requests over a window; vector checked on each
    task automatic count_irq(input int win, input logic [7:0] vec, output int cnt);
        cnt = 0;
        for (int k = 0; k < win; k++) begin
            @(negedge clk);
            if (irq_valid) begin
                cnt++;
                chk("R10 vector", irq_vector, vec);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int cnt;
        logic [63:0] d;
        logic [31:0] saved;
        logic [63:0] ts_hit;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R9, R11)
        chk("R9 armed after reset", timer_armed, 0);
        chk("R9 lowpower after reset", lowpower_ok, 1);
        chk("R10 no irq after reset", irq_valid, 0);
        rd_addr = A_INIT;  #1 chk("R11 init reset", rd_data, 0);
        rd_addr = A_ENTRY; #1 chk("R11 entry reset", rd_data, 0);
        rd_addr = 12'h100; #1 chk("R11 unmapped read", rd_data, 0);
        @(negedge clk);

        // Vector table: R1 one-shot, R2 periodic
        for (int i = 0; i < NVEC; i++) begin
            wr_reg(A_ENTRY, entry(TBL[i].mode, 1'b0, 8'h40 + 8'(i)));
            rd_addr = A_ENTRY; #1
            chk("R11 entry readback", rd_data, entry(TBL[i].mode, 1'b0, 8'h40 + 8'(i)));
            wr_reg(A_INIT, {16'd0, TBL[i].cnt});
            count_irq(TBL[i].win, 8'h40 + 8'(i), cnt);
            chk(TBL[i].mode == 2'd1 ? "R2 periodic irq count" : "R1 one-shot irq count", cnt, TBL[i].irqs);
            chk(TBL[i].mode == 2'd1 ? "R2 periodic stays armed" : "R1 one-shot disarms", timer_armed, TBL[i].armed);
            wr_reg(A_INIT, 32'd0);
            chk("R3 zero write disarms", timer_armed, 0);
        end

        // R1 count readback and exact expiry cycle
        wr_reg(A_ENTRY, entry(2'd0, 1'b0, 8'h21));
        wr_reg(A_INIT, 32'd10);
        rd_addr = A_CUR;
        idle(3);
        chk("R1 remaining count", rd_data, 7);
        idle(7);
        chk("R1 irq on Nth edge", irq_valid, 1);
        chk("R10 vector value", irq_vector, 8'h21);
        chk("R1 disarmed at expiry", timer_armed, 0);
        @(negedge clk);
        chk("R10 single cycle", irq_valid, 0);

        // R3 stop mid-count
        wr_reg(A_INIT, 32'd20);
        idle(5);
        wr_reg(A_INIT, 32'd0);
        chk("R3 stopped", timer_armed, 0);
        count_irq(30, 8'h21, cnt);
        chk("R3 no irq after stop", cnt, 0);

        // R7 mask in one-shot
        wr_reg(A_ENTRY, entry(2'd0, 1'b1, 8'h22));
        wr_reg(A_INIT, 32'd3);
        chk("R7 masked still armed", timer_armed, 1);
        count_irq(10, 8'h22, cnt);
        chk("R7 masked no irq", cnt, 0);
        chk("R7 masked expiry disarms", timer_armed, 0);

        // R8 mode change
        wr_reg(A_ENTRY, entry(2'd1, 1'b0, 8'h23));
        wr_reg(A_INIT, 32'd50);
        idle(2);
        chk("R8 periodic armed", timer_armed, 1);
        wr_reg(A_ENTRY, entry(2'd0, 1'b0, 8'h23));
        chk("R8 mode change disarms", timer_armed, 0);
        rd_addr = A_CUR; #1 chk("R8 count cleared", rd_data, 0);

        // R12 deadline write outside deadline mode
        wr_dl(ts_value + 64'd5);
        chk("R12 not armed", timer_armed, 0);
        count_irq(15, 8'h23, cnt);
        chk("R12 no irq", cnt, 0);

        // Deadline mode (R4, R5, R6, R9)
        wr_reg(A_ENTRY, entry(2'd2, 1'b0, 8'h77));
        chk("R8 entering deadline disarmed", timer_armed, 0);
        rd_addr = A_INIT; #1 saved = rd_data;
        d = ts_value + 64'd12;
        wr_dl(d);
        chk("R6 deadline armed", timer_armed, 1);
        chk("R9 lowpower blocked", lowpower_ok, 0);
        wr_reg(A_INIT, 32'd0);
        chk("R4 zero count write ignored", timer_armed, 1);
        wr_reg(A_INIT, 32'd9);
        rd_addr = A_INIT; #1 chk("R4 start count unchanged", rd_data, saved);
        rd_addr = A_CUR;  #1 chk("R4 count reads zero", rd_data, 0);
        cnt = 0; ts_hit = '0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (irq_valid) begin
                cnt++;
                ts_hit = ts_value;
                chk("R10 deadline vector", irq_vector, 8'h77);
            end
        end
        chk("R5 fires once", cnt, 1);
        chk("R5 fire cycle", ts_hit, d + 64'd1);
        chk("R6 armed after firing", timer_armed, 1);
        wr_dl(64'd0);
        chk("R6 zero deadline disarms", timer_armed, 0);
        chk("R9 lowpower allowed", lowpower_ok, 1);

        // R5 deadline already past
        wr_dl(64'd1);
        count_irq(10, 8'h77, cnt);
        chk("R5 past deadline fires once", cnt, 1);

        // R7 mask in deadline mode
        wr_reg(A_ENTRY, entry(2'd2, 1'b1, 8'h77));
        wr_dl(ts_value + 64'd4);
        count_irq(15, 8'h77, cnt);
        chk("R7 masked deadline no irq", cnt, 0);
        chk("R7 masked deadline armed", timer_armed, 1);
        wr_dl(64'd0);
        chk("R6 final disarm", timer_armed, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule